// File: doc/BRIEF.md
# Sectored Two-Way Write-Through Cache

This block is a unified 8 KB cache shared by instruction and data traffic. It sits between a CPU-side request port and a memory port. Storage is two ways of 64 sets. Each 64-byte line is divided into four 16-byte sectors. Every sector has its own valid flag, so a read miss fetches only the 16 bytes that were asked for. A read returns one whole sector, which is four 32-bit words, in a single beat. A write carries one sector-wide beat of two 64-bit doublewords, with a byte-enable mask.

Every write is sent on to memory. A write that hits also merges its enabled bytes into the cached sector in the same cycle. A write that misses leaves the cache untouched. One least-recently-used bit per set chooses the way to replace when a new line is allocated. The cache is blocking: while a refill or a memory write is outstanding, `cpu_ready` stays low and requests are not accepted.

Address split (32-bit byte address): bits [3:0] give the byte within a sector, bits [5:4] the sector, bits [11:6] the set, and bits [31:12] the tag.

Top module: `swc_cache`

## Requirements
- R1: After reset, `cpu_ready` is 1, `mem_req` is 0 and `cpu_rvalid` is 0. Every sector is invalid, so the first read of any address misses. Every per-set LRU bit points at way 0.
- R2: A request is accepted on a clock edge where `cpu_req` and `cpu_ready` are both 1. A read that hits a valid sector raises `cpu_rvalid` for one cycle, in the cycle after acceptance. `cpu_rdata` then carries that sector, with byte i on bits [8i+7:8i]. No memory request is made and `cpu_ready` stays 1.
- R3: A read whose tag is present in a way, but whose sector is invalid, fetches only that sector into that way. `mem_addr` is the address with bits [3:0] cleared. The other sectors of the line keep their valid state.
- R4: A read whose tag is present in neither way replaces the way that the set's LRU bit names. All four of that way's sector valid flags are cleared, the new tag is written, and only the requested sector is fetched.
- R5: A read hit, a write hit or a completed refill marks the way it used as most recent. The LRU bit then names the other way.
- R6: Every accepted write, hit or miss, asserts `mem_req` with `mem_we`=1 in the next cycle. It presents the sector-aligned address, `cpu_wdata` and `cpu_be`, and holds them until `mem_ack`.
- R7: A write hit replaces the cached bytes whose `cpu_be` bit is 1 (bit i enables byte i) and keeps the other bytes. A later read hit returns the merged sector.
- R8: A write miss allocates nothing. A later read of the same sector still misses.
- R9: While a refill or a memory write is outstanding, `cpu_ready` is 0 and `cpu_req` is ignored. No second memory transfer is started for it.
- R10: A refill completes on the edge where `mem_ack` is 1. `cpu_rvalid` is 1 in the next cycle, with `cpu_rdata` equal to the `mem_rdata` sampled on that edge, and `cpu_ready` is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU request valid |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 128 | Write data, two doublewords |
| cpu_be | input | 16 | Byte enables for writes |
| cpu_ready | output | 1 | Cache can accept a request |
| cpu_rvalid | output | 1 | Read data valid, one cycle |
| cpu_rdata | output | 128 | Read sector, four words |
| mem_req | output | 1 | Memory transfer pending |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | 32 | Sector-aligned address |
| mem_wdata | output | 128 | Data for memory write |
| mem_be | output | 16 | Byte enables (all ones on reads) |
| mem_ack | input | 1 | Memory completes transfer |
| mem_rdata | input | 128 | Refill data, valid with mem_ack |

## Verification
Two functions can fall in the same cycle. A write hit merges bytes into the data array and moves the LRU bit, and on that same edge it starts the memory write. Separately, the end of a refill writes the sector and its valid flag, and it also answers the CPU, while a new request is already being held on `cpu_req` against a low `cpu_ready`. Random mixes of reads and partial writes over three tags in three sets are driven against a bench model of tags, sector flags and LRU bits, with randomized memory latency. Each read is judged by two things: whether memory was consulted, and whether the returned sector equals the bench's memory image, which receives every write.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_WSEND = 2'd2
  } swc_state_t;

  // LRU bit names the way to evict next: the one not just used.
  function automatic logic lru_after_use(input logic used_way);
    return ~used_way;
  endfunction
endpackage

// File: rtl/swc_dir.sv
module swc_dir #(
  parameter int SETS    = 64,
  parameter int SECTORS = 4,
  parameter int TAG_W   = 20,
  parameter int IDX_W   = 6,
  parameter int SEC_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] look_idx,
  input  logic [TAG_W-1:0] look_tag,
  input  logic [SEC_W-1:0] look_sect,
  output logic [1:0]       way_line,
  output logic [1:0]       way_sect,
  output logic             lru_way,
  input  logic             fill_en,
  input  logic             fill_new,
  input  logic             fill_way,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [SEC_W-1:0] fill_sect,
  input  logic             touch_en,
  input  logic             touch_way,
  input  logic [IDX_W-1:0] touch_idx
);
  import swc_pkg::*;
  localparam int WAYS = 2;

  logic [SETS-1:0] lru_q;
  logic [SECTORS-1:0] sect_bit;
  assign sect_bit = SECTORS'(1) << fill_sect;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0]   tag_q [SETS];
    logic [SECTORS-1:0] vld_q [SETS];
    logic               sel;
    assign sel = fill_en && (fill_way == 1'(w));
    assign way_line[w] = (tag_q[look_idx] == look_tag) && (|vld_q[look_idx]);
    assign way_sect[w] = vld_q[look_idx][look_sect];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      end else if (sel) begin
        vld_q[fill_idx] <= fill_new ? sect_bit : (vld_q[fill_idx] | sect_bit);
      end
    end

    always_ff @(posedge clk) begin
      if (sel && fill_new) tag_q[fill_idx] <= fill_tag;
    end
  end

  assign lru_way = lru_q[look_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lru_q <= '0;
    else if (touch_en) lru_q[touch_idx] <= lru_after_use(touch_way);
  end

  // R4: a tag is never held by both ways of a set
  a_r4_unique_tag: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_line));
  // R5: a touch leaves the LRU bit naming the other way
  a_r5_lru_flip: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> (lru_q[$past(touch_idx)] != $past(touch_way)));
endmodule

// File: rtl/swc_data.sv
module swc_data #(
  parameter int SETS       = 64,
  parameter int SECTORS    = 4,
  parameter int SECT_BYTES = 16,
  parameter int IDX_W      = 6,
  parameter int SEC_W      = 2
) (
  input  logic                    clk,
  input  logic                    rd_way,
  input  logic [IDX_W-1:0]        rd_idx,
  input  logic [SEC_W-1:0]        rd_sect,
  output logic [SECT_BYTES*8-1:0] rd_data,
  input  logic                    wr_en,
  input  logic                    wr_way,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [SEC_W-1:0]        wr_sect,
  input  logic [SECT_BYTES*8-1:0] wr_data,
  input  logic [SECT_BYTES-1:0]   wr_be
);
  localparam int DATA_W = SECT_BYTES * 8;
  localparam int AW     = 1 + IDX_W + SEC_W;

  logic [DATA_W-1:0] arr_q [2**AW];

  function automatic logic [DATA_W-1:0] merge_bytes(
      input logic [DATA_W-1:0] old_v, input logic [DATA_W-1:0] new_v,
      input logic [SECT_BYTES-1:0] be);
    logic [DATA_W-1:0] r;
    r = old_v;
    for (int b = 0; b < SECT_BYTES; b++)
      if (be[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
    return r;
  endfunction

  logic [AW-1:0] waddr;
  assign waddr   = {wr_way, wr_idx, wr_sect};
  assign rd_data = arr_q[{rd_way, rd_idx, rd_sect}];

  always_ff @(posedge clk) begin
    if (wr_en) arr_q[waddr] <= merge_bytes(arr_q[waddr], wr_data, wr_be);
  end
endmodule

// File: rtl/swc_ctrl.sv
module swc_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int SECT_BYTES = 16,
  parameter int TAG_W      = 20,
  parameter int IDX_W      = 6,
  parameter int SEC_W      = 2,
  parameter int OFS_W      = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [SECT_BYTES*8-1:0] cpu_wdata,
  input  logic [SECT_BYTES-1:0]   cpu_be,
  output logic                    cpu_ready,
  input  logic [1:0]              way_line,
  input  logic [1:0]              way_sect,
  input  logic                    lru_way,
  input  logic                    mem_ack,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [SECT_BYTES*8-1:0] mem_wdata,
  output logic [SECT_BYTES-1:0]   mem_be,
  output logic [IDX_W-1:0]        look_idx,
  output logic [TAG_W-1:0]        look_tag,
  output logic [SEC_W-1:0]        look_sect,
  output logic                    hit_way,
  output logic                    rd_hit,
  output logic                    wr_hit,
  output logic                    fill_done,
  output logic                    fill_new,
  output logic                    fill_way,
  output logic [IDX_W-1:0]        fill_idx,
  output logic [TAG_W-1:0]        fill_tag,
  output logic [SEC_W-1:0]        fill_sect
);
  import swc_pkg::*;

  swc_state_t               state_q;
  logic [ADDR_W-1:0]        addr_q;
  logic                     we_q;
  logic [SECT_BYTES*8-1:0]  wdata_q;
  logic [SECT_BYTES-1:0]    be_q;
  logic                     way_q;
  logic                     new_q;
  logic                     accept;
  logic                     sect_hit;
  logic                     rd_miss;

  assign look_sect = cpu_addr[OFS_W +: SEC_W];
  assign look_idx  = cpu_addr[OFS_W+SEC_W +: IDX_W];
  assign look_tag  = cpu_addr[ADDR_W-1 -: TAG_W];

  assign cpu_ready = (state_q == ST_IDLE);
  assign accept    = cpu_req && cpu_ready;
  assign sect_hit  = |(way_line & way_sect);
  assign hit_way   = way_line[1];
  assign rd_hit    = accept && !cpu_we && sect_hit;
  assign wr_hit    = accept && cpu_we && sect_hit;
  assign rd_miss   = accept && !cpu_we && !sect_hit;
  assign fill_done = (state_q == ST_FILL) && mem_ack;

  assign fill_new  = new_q;
  assign fill_way  = way_q;
  assign fill_sect = addr_q[OFS_W +: SEC_W];
  assign fill_idx  = addr_q[OFS_W+SEC_W +: IDX_W];
  assign fill_tag  = addr_q[ADDR_W-1 -: TAG_W];

  assign mem_req   = (state_q != ST_IDLE);
  assign mem_we    = we_q;
  assign mem_addr  = {addr_q[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
  assign mem_wdata = wdata_q;
  assign mem_be    = we_q ? be_q : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      be_q    <= '0;
      way_q   <= 1'b0;
      new_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          addr_q  <= cpu_addr;
          we_q    <= cpu_we;
          wdata_q <= cpu_wdata;
          be_q    <= cpu_be;
          if (cpu_we) state_q <= ST_WSEND;
          else if (rd_miss) begin
            state_q <= ST_FILL;
            new_q   <= !(|way_line);
            way_q   <= (|way_line) ? hit_way : lru_way;
          end
        end
        ST_FILL:  if (mem_ack) state_q <= ST_IDLE;
        ST_WSEND: if (mem_ack) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  // R6: every accepted write goes to memory next cycle
  a_r6_write_through: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cpu_we) |=> (mem_req && mem_we));
  // R8: a write never leads to a refill
  a_r8_write_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cpu_we) |=> !fill_done);
  // R9: memory transfer held until acknowledged, CPU blocked meanwhile
  a_r9_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && !cpu_ready && $stable(mem_addr)));
  // R4: a new line goes to the LRU way when no tag matches
  a_r4_victim: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_miss && !(|way_line)) |=> (fill_way == $past(lru_way)));
endmodule

// File: rtl/swc_cache.sv
module swc_cache #(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 64,
  parameter int SECTORS    = 4,
  parameter int SECT_BYTES = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [SECT_BYTES*8-1:0] cpu_wdata,
  input  logic [SECT_BYTES-1:0]   cpu_be,
  output logic                    cpu_ready,
  output logic                    cpu_rvalid,
  output logic [SECT_BYTES*8-1:0] cpu_rdata,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [SECT_BYTES*8-1:0] mem_wdata,
  output logic [SECT_BYTES-1:0]   mem_be,
  input  logic                    mem_ack,
  input  logic [SECT_BYTES*8-1:0] mem_rdata
);
  localparam int OFS_W  = $clog2(SECT_BYTES);
  localparam int SEC_W  = $clog2(SECTORS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFS_W - SEC_W - IDX_W;
  localparam int DATA_W = SECT_BYTES * 8;

  logic [IDX_W-1:0]  look_idx, fill_idx, touch_idx;
  logic [TAG_W-1:0]  look_tag, fill_tag;
  logic [SEC_W-1:0]  look_sect, fill_sect;
  logic [1:0]        way_line, way_sect;
  logic              lru_way, hit_way, rd_hit, wr_hit;
  logic              fill_done, fill_new, fill_way, touch_en, touch_way;
  logic              arr_wr_en, arr_wr_way;
  logic [IDX_W-1:0]  arr_wr_idx;
  logic [SEC_W-1:0]  arr_wr_sect;
  logic [DATA_W-1:0] arr_wr_data, arr_rd_data, rdata_q;
  logic [SECT_BYTES-1:0] arr_wr_be;
  logic              rvalid_q;

  swc_ctrl #(.ADDR_W(ADDR_W), .SECT_BYTES(SECT_BYTES), .TAG_W(TAG_W),
             .IDX_W(IDX_W), .SEC_W(SEC_W), .OFS_W(OFS_W)) u_ctrl (
    .clk, .rst_n, .cpu_req, .cpu_we, .cpu_addr, .cpu_wdata, .cpu_be, .cpu_ready,
    .way_line, .way_sect, .lru_way, .mem_ack, .mem_req, .mem_we, .mem_addr,
    .mem_wdata, .mem_be, .look_idx, .look_tag, .look_sect, .hit_way, .rd_hit,
    .wr_hit, .fill_done, .fill_new, .fill_way, .fill_idx, .fill_tag, .fill_sect);

  // Touches at acceptance use the live lookup; refill touches use the held address.
  assign touch_en  = rd_hit || wr_hit || fill_done;
  assign touch_way = fill_done ? fill_way : hit_way;
  assign touch_idx = fill_done ? fill_idx : look_idx;

  swc_dir #(.SETS(SETS), .SECTORS(SECTORS), .TAG_W(TAG_W), .IDX_W(IDX_W),
            .SEC_W(SEC_W)) u_dir (
    .clk, .rst_n, .look_idx, .look_tag, .look_sect, .way_line, .way_sect,
    .lru_way, .fill_en(fill_done), .fill_new, .fill_way, .fill_idx, .fill_tag,
    .fill_sect, .touch_en, .touch_way, .touch_idx);

  assign arr_wr_en   = wr_hit || fill_done;
  assign arr_wr_way  = fill_done ? fill_way : hit_way;
  assign arr_wr_idx  = fill_done ? fill_idx : look_idx;
  assign arr_wr_sect = fill_done ? fill_sect : look_sect;
  assign arr_wr_data = fill_done ? mem_rdata : cpu_wdata;
  assign arr_wr_be   = fill_done ? '1 : cpu_be;

  swc_data #(.SETS(SETS), .SECTORS(SECTORS), .SECT_BYTES(SECT_BYTES),
             .IDX_W(IDX_W), .SEC_W(SEC_W)) u_data (
    .clk, .rd_way(hit_way), .rd_idx(look_idx), .rd_sect(look_sect),
    .rd_data(arr_rd_data), .wr_en(arr_wr_en), .wr_way(arr_wr_way),
    .wr_idx(arr_wr_idx), .wr_sect(arr_wr_sect), .wr_data(arr_wr_data),
    .wr_be(arr_wr_be));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_hit || fill_done;
      if (rd_hit)         rdata_q <= arr_rd_data;
      else if (fill_done) rdata_q <= mem_rdata;
    end
  end

  assign cpu_rvalid = rvalid_q;
  assign cpu_rdata  = rdata_q;

  // R2: a read hit answers next cycle without touching memory
  a_r2_hit_resp: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> (cpu_rvalid && !mem_req));
  // R10: refill data is returned the cycle after mem_ack
  a_r10_fill_resp: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> (cpu_rvalid && cpu_ready && cpu_rdata == $past(mem_rdata)));
endmodule

// File: tb/swc_cache_tb.sv
`timescale 1ns/1ps
module swc_cache_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0]  cpu_addr = '0;
  logic [127:0] cpu_wdata = '0;
  logic [15:0]  cpu_be = '0;
  logic         cpu_ready, cpu_rvalid;
  logic [127:0] cpu_rdata;
  logic         mem_req, mem_we;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic [15:0]  mem_be;
  logic         mem_ack = 1'b0;
  logic [127:0] mem_rdata = '0;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  swc_cache u_dut (.*);

  // Bench memory image, keyed by sector address.
  logic [127:0] store [logic [31:0]];
  function automatic logic [127:0] dflt(input logic [31:0] a);
    return {a ^ 32'h1357_9BDF, a * 32'd3, ~a, a + 32'h0F0F_0F0F};
  endfunction
  function automatic logic [127:0] peek(input logic [31:0] a);
    return store.exists(a) ? store[a] : dflt(a);
  endfunction

  // Reference directory: tags, sector flags, LRU per set.
  int       m_tag [2][64];
  bit [3:0] m_vld [2][64];
  bit       m_lru [64];

  function automatic int line_way(input logic [31:0] a);
    for (int w = 0; w < 2; w++)
      if (m_vld[w][a[11:6]] != 0 && m_tag[w][a[11:6]] == int'(a[31:12])) return w;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory responder with random latency.
  int lat = 1;
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        lat = 1 + ($urandom % 4);
      end else if (mem_req) begin
        if (lat == 0) begin
          mem_ack = 1'b1;
          if (mem_we) begin
            logic [127:0] v;
            v = peek(mem_addr);
            for (int b = 0; b < 16; b++)
              if (mem_be[b]) v[b*8 +: 8] = mem_wdata[b*8 +: 8];
            store[mem_addr] = v;
          end else mem_rdata = peek(mem_addr);
        end else lat--;
      end
    end
  end

  task automatic wait_ready();
    int n = 0;
    while (!cpu_ready && n < 100) begin @(negedge clk); n++; end
  endtask

  task automatic do_read(input logic [31:0] a, input bit poke, input string tagmsg);
    int  w, n;
    bit  exp_hit, saw_mem, saw_wr, blk_ok;
    logic [6:0] s;
    logic [1:0] sc;
    string lbl;
    s = {1'b0, a[11:6]}; sc = a[5:4];
    wait_ready();
    w = line_way(a);
    exp_hit = (w >= 0) && m_vld[w][s[5:0]][sc];
    lbl = (tagmsg != "") ? tagmsg : (exp_hit ? "R2" : (w >= 0 ? "R3" : "R4"));
    cpu_req = 1; cpu_we = 0; cpu_addr = a;
    @(posedge clk); @(negedge clk);
    if (poke) begin
      cpu_we = 1; cpu_addr = a ^ 32'h0000_1000; cpu_wdata = '1; cpu_be = '1;
    end else cpu_req = 0;
    saw_mem = 0; saw_wr = 0; blk_ok = 1; n = 0;
    while (!cpu_rvalid && n < 100) begin
      if (mem_req) begin
        saw_mem = 1;
        if (mem_we) saw_wr = 1;
        if (cpu_ready) blk_ok = 0;
        if (mem_addr != {a[31:4], 4'h0}) blk_ok = 0;
      end
      @(negedge clk); n++;
    end
    cpu_req = 0; cpu_we = 0;
    chk(saw_mem == !exp_hit, {lbl, " hit/miss"}, 128'(saw_mem), 128'(!exp_hit));
    chk(cpu_rvalid && cpu_rdata == peek({a[31:4], 4'h0}),
        exp_hit ? "R2 data" : "R10 data", cpu_rdata, peek({a[31:4], 4'h0}));
    if (exp_hit) chk(cpu_ready && !mem_req, "R2 ready", 128'(cpu_ready), 128'd1);
    else begin
      chk(blk_ok, "R9 blocked, R3 addr", 128'(blk_ok), 128'd1);
      chk(cpu_ready, "R10 ready", 128'(cpu_ready), 128'd1);
    end
    if (poke) chk(!saw_wr, "R9 ignored req", 128'(saw_wr), 128'd0);
    if (exp_hit) m_lru[s[5:0]] = ~w[0];
    else if (w >= 0) begin
      m_vld[w][s[5:0]][sc] = 1; m_lru[s[5:0]] = ~w[0];
    end else begin
      w = int'(m_lru[s[5:0]]);
      m_tag[w][s[5:0]] = int'(a[31:12]);
      m_vld[w][s[5:0]] = 4'b0001 << sc;
      m_lru[s[5:0]] = ~w[0];
    end
    @(negedge clk);
  endtask

  task automatic do_write(input logic [31:0] a, input logic [127:0] d,
                          input logic [15:0] be);
    int w, n;
    wait_ready();
    w = line_way(a);
    cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d; cpu_be = be;
    @(posedge clk); @(negedge clk);
    cpu_req = 0; cpu_we = 0;
    chk(mem_req && mem_we && mem_addr == {a[31:4], 4'h0}, "R6 req/addr",
        128'(mem_addr), 128'({a[31:4], 4'h0}));
    chk(mem_wdata == d && mem_be == be, "R6 data/be", mem_wdata, d);
    chk(!cpu_ready, "R9 ready low on write", 128'(cpu_ready), 128'd0);
    n = 0;
    while (!cpu_ready && n < 100) begin @(negedge clk); n++; end
    if (w >= 0 && m_vld[w][a[11:6]][a[5:4]]) m_lru[a[11:6]] = ~w[0];
  endtask

  function automatic logic [31:0] mk(input int tg, input int st, input int sc);
    return {20'(tg), 6'(st), 2'(sc), 4'($urandom % 16)};
  endfunction

  initial begin
    int seed_dummy;
    seed_dummy = int'($urandom(32'd4711));
    for (int s = 0; s < 64; s++) begin
      m_vld[0][s] = 0; m_vld[1][s] = 0; m_lru[s] = 0;
      m_tag[0][s] = 0; m_tag[1][s] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cpu_ready && !mem_req && !cpu_rvalid, "R1 reset outputs",
        128'({cpu_ready, mem_req, cpu_rvalid}), 128'b100);

    do_read(mk(7, 3, 0), 0, "R1 first miss");
    // LRU ordering in set 9
    do_read(mk(10, 9, 0), 0, "R4");
    do_read(mk(11, 9, 0), 0, "R4");
    do_read(mk(10, 9, 0), 0, "R5");
    do_read(mk(12, 9, 0), 0, "R5");
    do_read(mk(10, 9, 0), 0, "R5");
    do_read(mk(11, 9, 0), 0, "R5");
    // Sector refill keeps other sectors
    do_read(mk(10, 9, 2), 0, "R3");
    do_read(mk(10, 9, 0), 0, "R3");
    // Write hit merge, then read back
    do_write(mk(10, 9, 2), {4{32'hDEAD_BEEF}}, 16'h0F3C);
    do_read(mk(10, 9, 2), 0, "R7");
    // Write miss does not allocate
    do_write(mk(30, 20, 1), {4{32'h1234_5678}}, 16'hFFFF);
    do_read(mk(30, 20, 1), 0, "R8");
    // Blocking with a request held during refill
    do_read(mk(40, 21, 3), 1, "R9");

    for (int i = 0; i < 600; i++) begin
      int tg, st;
      tg = 1 + ($urandom % 3);
      case ($urandom % 3) 0: st = 0; 1: st = 5; default: st = 63; endcase
      if (($urandom % 10) < 6) do_read(mk(tg, st, $urandom % 4), ($urandom % 8) == 0, "");
      else do_write(mk(tg, st, $urandom % 4),
                    {$urandom, $urandom, $urandom, $urandom},
                    (($urandom % 4) == 0) ? 16'hFFFF : 16'($urandom));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule